// File: doc/BRIEF.md
# Counted Block-Transfer Sequencer

This block runs the repeated data beats of a block transfer on the master side of a system bus. Software loads a byte count and then writes an active-low enable bit to 0. If the count is nonzero, the sequencer loads its beat address from the processor address and raises a beat request. Each acknowledged beat lowers the count by the beat size and advances the address by the same amount. The transfer stops when the count reaches zero or when the bus reports an error, whichever happens first.

When the transfer ends, the enable bit returns to 1 and a one-cycle done pulse is issued. The electrical protocol of the bus is handled elsewhere, and this block only sees a request and acknowledge pair.

For a processor with 24 address lines, a legacy mode uses the top byte of the count register as bits 31..24 of the bus address. In this mode only the lower 24 bits of the count are counted down.

Top module: `blkx_seq`

## Requirements
- R1: A transfer starts (busy and beat_req go to 1) only when the enable bit reads 0 and the active part of the count is nonzero. Clearing the enable bit while the count is zero starts nothing.
- R2: Each acknowledged beat lowers the count by the beat size, and the count saturates at zero. The beat_size codes are 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes.
- R3: An acknowledged beat that brings the active count to zero ends the transfer: busy and beat_req are 0 in the next cycle.
- R4: A bus_err high during a transfer ends it at the next edge. The count and the address keep the values left by the last acknowledged beat. When bus_err and beat_ack are high in the same cycle, the error wins and the beat is not counted.
- R5: With legacy_mode = 1, bus_addr is count[31:24] followed by address bits 23..0. Only count[23:0] is decremented and tested for zero, and count[31:24] is held.
- R6: At start the beat address is loaded from cpu_addr. After each acknowledged beat it increases by the beat size, wrapping modulo 2^32. With legacy_mode = 0, bus_addr is that address.
- R7: When a transfer ends, whether by completion or by error, the enable bit reads 1 and done is high for exactly one cycle.
- R8: A count write while busy is ignored. A count write while idle is returned on cnt_rdata in the next cycle.
- R9: After reset the count is 0, the enable bit is 1, and busy, done, beat_req and bus_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 32 | Count write data |
| cnt_rdata | output | 32 | Current count register |
| en_wr | input | 1 | Enable bit write strobe (honoured while idle) |
| en_wdata | input | 1 | Enable bit value; 0 requests a transfer |
| blk_en_n | output | 1 | Current enable bit, active low |
| legacy_mode | input | 1 | 1 selects the 24-bit processor address mode |
| beat_size | input | 2 | Beat size code |
| cpu_addr | input | 32 | Start address from the processor |
| beat_req | output | 1 | Beat request to the bus side |
| beat_ack | input | 1 | Beat acknowledge |
| bus_err | input | 1 | Bus error |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| bus_addr | output | 32 | Address of the current beat |

## Verification
Two events can fall in the same cycle: a beat acknowledge and a bus error, and also the final beat and an ignored count write. The bench provokes the first by driving beat_ack and bus_err together in one vector, including on the very first beat. It then judges that no extra byte was counted and that the address did not move. In every vector it also drives a count write during the first beat and checks that the final count matches the value expected from the beats alone.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

   typedef enum logic [0:0] {
      BX_IDLE = 1'b0,
      BX_RUN  = 1'b1
   } bx_state_e;

   localparam int unsigned BX_STEP_W = 3;

   // beat size code to byte count: 0 -> 1, 1 -> 2, 2 and 3 -> 4
   function automatic logic [BX_STEP_W-1:0] bx_bytes(input logic [1:0] code);
      logic [BX_STEP_W-1:0] r;
      case (code)
         2'd0:    r = 3'd1;
         2'd1:    r = 3'd2;
         default: r = 3'd4;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/blkx_ctrl.sv
module blkx_ctrl
   import blkx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_wr,
   input  logic en_wdata,
   input  logic cnt_zero,
   input  logic last_beat,
   input  logic beat_ack,
   input  logic bus_err,
   output logic busy,
   output logic beat_req,
   output logic start,
   output logic step,
   output logic done,
   output logic en_n
);

   bx_state_e st_q, st_d;
   logic      en_n_q;
   logic      done_q;
   logic      finish;
   logic      in_run;

   assign in_run = (st_q == BX_RUN);
   assign start  = (st_q == BX_IDLE) && !en_n_q && !cnt_zero;
   assign step   = in_run && beat_ack && !bus_err;
   assign finish = in_run && (bus_err || (beat_ack && last_beat));

   always_comb begin
      st_d = st_q;
      case (st_q)
         BX_IDLE: if (start)  st_d = BX_RUN;
         BX_RUN:  if (finish) st_d = BX_IDLE;
         default:             st_d = BX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= BX_IDLE;
         en_n_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= finish;
         if (finish)
            en_n_q <= 1'b1;
         else if (en_wr && (st_q == BX_IDLE))
            en_n_q <= en_wdata;
      end
   end

   assign busy     = in_run;
   assign beat_req = in_run;
   assign done     = done_q;
   assign en_n     = en_n_q;

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!en_n_q && !cnt_zero));                       // R1
   AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last_beat) |=> !busy);                                     // R3
   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_err) |=> (!busy && done));                             // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                    // R7
   AST_EN_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> en_n);                                                     // R7

endmodule

// File: rtl/blkx_count.sv
module blkx_count
   import blkx_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned EXT_W     = 8,
   parameter bit          LEGACY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 legacy,
   input  logic                 wr,
   input  logic [CNT_W-1:0]     wdata,
   input  logic                 busy,
   input  logic                 step,
   input  logic [BX_STEP_W-1:0] bytes,
   output logic [CNT_W-1:0]     cnt,
   output logic [EXT_W-1:0]     ext,
   output logic                 cnt_zero,
   output logic                 last_beat
);

   localparam int unsigned LOW_W = CNT_W - EXT_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] act;
   logic [CNT_W-1:0] dec_act;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] bytes_w;

   assign bytes_w = CNT_W'(bytes);

   generate
      if (LEGACY_EN) begin : g_leg
         assign act = legacy ? {{EXT_W{1'b0}}, cnt_q[LOW_W-1:0]} : cnt_q;
         assign nxt = legacy ? {cnt_q[CNT_W-1 -: EXT_W], dec_act[LOW_W-1:0]} : dec_act;
         assign ext = cnt_q[CNT_W-1 -: EXT_W];

         AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (step && legacy) |=> (cnt_q[CNT_W-1 -: EXT_W] == $past(cnt_q[CNT_W-1 -: EXT_W]))); // R5
      end else begin : g_flat
         logic unused_leg;
         assign unused_leg = legacy;
         assign act = cnt_q;
         assign nxt = dec_act;
         assign ext = '0;
      end
   endgenerate

   assign dec_act   = (act > bytes_w) ? (act - bytes_w) : '0;
   assign cnt_zero  = (act == '0);
   assign last_beat = (act <= bytes_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step)
         cnt_q <= nxt;
      else if (wr && !busy)
         cnt_q <= wdata;
   end

   assign cnt = cnt_q;

   AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr && !step) |=> $stable(cnt_q));                          // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt_q <= $past(cnt_q)));                                  // R2

endmodule

// File: rtl/blkx_addr.sv
module blkx_addr
   import blkx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned EXT_W     = 8,
   parameter bit          LEGACY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 legacy,
   input  logic                 start,
   input  logic                 step,
   input  logic                 busy,
   input  logic [BX_STEP_W-1:0] bytes,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [EXT_W-1:0]     ext,
   output logic [ADDR_W-1:0]    bus_addr
);

   localparam int unsigned PROC_W = ADDR_W - EXT_W;

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (start)
         addr_q <= cpu_addr;
      else if (step)
         addr_q <= addr_q + ADDR_W'(bytes);
   end

   generate
      if (LEGACY_EN) begin : g_leg
         assign bus_addr = legacy ? {ext, addr_q[PROC_W-1:0]} : addr_q;
      end else begin : g_flat
         logic unused_sel;
         assign unused_sel = ^{ext, legacy};
         assign bus_addr   = addr_q;
      end
   endgenerate

   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (addr_q == $past(addr_q) + ADDR_W'($past(bytes))));        // R6
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> $stable(addr_q));                               // R4

endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
   import blkx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned EXT_W     = 8,
   parameter bit          LEGACY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   output logic [CNT_W-1:0]  cnt_rdata,
   input  logic              en_wr,
   input  logic              en_wdata,
   output logic              blk_en_n,
   input  logic              legacy_mode,
   input  logic [1:0]        beat_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              beat_req,
   input  logic              beat_ack,
   input  logic              bus_err,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] bus_addr
);

   generate
      if (EXT_W == 0 || EXT_W >= ADDR_W) begin : g_bad_ext_addr
         $error("blkx_seq: EXT_W must lie between 1 and ADDR_W-1");
      end
      if (EXT_W >= CNT_W) begin : g_bad_ext_cnt
         $error("blkx_seq: EXT_W must be below CNT_W");
      end
      if (CNT_W < BX_STEP_W + 1) begin : g_bad_cnt
         $error("blkx_seq: CNT_W too narrow for the largest beat");
      end
   endgenerate

   logic                 start_w;
   logic                 step_w;
   logic                 cnt_zero_w;
   logic                 last_w;
   logic                 busy_w;
   logic [BX_STEP_W-1:0] bytes_w;
   logic [EXT_W-1:0]     ext_w;

   assign bytes_w = bx_bytes(beat_size);

   blkx_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_wr     (en_wr),
      .en_wdata  (en_wdata),
      .cnt_zero  (cnt_zero_w),
      .last_beat (last_w),
      .beat_ack  (beat_ack),
      .bus_err   (bus_err),
      .busy      (busy_w),
      .beat_req  (beat_req),
      .start     (start_w),
      .step      (step_w),
      .done      (done),
      .en_n      (blk_en_n)
   );

   blkx_count #(
      .CNT_W     (CNT_W),
      .EXT_W     (EXT_W),
      .LEGACY_EN (LEGACY_EN)
   ) i_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .legacy    (legacy_mode),
      .wr        (cnt_wr),
      .wdata     (cnt_wdata),
      .busy      (busy_w),
      .step      (step_w),
      .bytes     (bytes_w),
      .cnt       (cnt_rdata),
      .ext       (ext_w),
      .cnt_zero  (cnt_zero_w),
      .last_beat (last_w)
   );

   blkx_addr #(
      .ADDR_W    (ADDR_W),
      .EXT_W     (EXT_W),
      .LEGACY_EN (LEGACY_EN)
   ) i_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .legacy    (legacy_mode),
      .start     (start_w),
      .step      (step_w),
      .busy      (busy_w),
      .bytes     (bytes_w),
      .cpu_addr  (cpu_addr),
      .ext       (ext_w),
      .bus_addr  (bus_addr)
   );

   assign busy = busy_w;

   AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      beat_req |-> busy);                                                 // R1
   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy && !done));                                 // R9

endmodule

// File: tb/test_blkx_seq.sv
module test_blkx_seq;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC       = 9;

   typedef struct packed {
      logic        leg;
      logic [1:0]  sz;
      logic [31:0] cnt;
      logic [31:0] cpu;
      logic [7:0]  errb;   // beat index that sees the error, FF = none
      logic        eboth;  // drive beat_ack together with bus_err
      logic [7:0]  beats;
      logic [31:0] ecnt;
      logic [31:0] eaddr;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 2'd2, 32'd16,         32'h1000_0000, 8'hFF, 1'b0, 8'd4, 32'd0,          32'h1000_0010},
      '{1'b0, 2'd0, 32'd3,          32'h0000_00FF, 8'hFF, 1'b0, 8'd3, 32'd0,          32'h0000_0102},
      '{1'b0, 2'd1, 32'd5,          32'h0000_0020, 8'hFF, 1'b0, 8'd3, 32'd0,          32'h0000_0026},
      '{1'b0, 2'd2, 32'd5,          32'h0000_0040, 8'hFF, 1'b0, 8'd2, 32'd0,          32'h0000_0048},
      '{1'b0, 2'd2, 32'd32,         32'h0000_0080, 8'd2,  1'b0, 8'd2, 32'd24,         32'h0000_0088},
      '{1'b1, 2'd2, 32'hAB00_000C, 32'hFF12_3456, 8'hFF, 1'b0, 8'd3, 32'hAB00_0000, 32'hAB12_3462},
      '{1'b1, 2'd1, 32'h5500_0010, 32'h00FF_FFFE, 8'd1,  1'b1, 8'd1, 32'h5500_000E, 32'h5500_0000},
      '{1'b0, 2'd3, 32'd8,          32'hFFFF_FFFC, 8'hFF, 1'b0, 8'd2, 32'd0,          32'h0000_0004},
      '{1'b0, 2'd0, 32'd10,         32'h0000_0300, 8'd0,  1'b1, 8'd0, 32'd10,         32'h0000_0300}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_wr = 1'b0;
   logic [31:0] cnt_wdata = '0;
   logic [31:0] cnt_rdata;
   logic        en_wr = 1'b0;
   logic        en_wdata = 1'b1;
   logic        blk_en_n;
   logic        legacy_mode = 1'b0;
   logic [1:0]  beat_size = 2'd0;
   logic [31:0] cpu_addr = '0;
   logic        beat_req;
   logic        beat_ack = 1'b0;
   logic        bus_err = 1'b0;
   logic        busy;
   logic        done;
   logic [31:0] bus_addr;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blkx_seq i_blkx_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_wr      (cnt_wr),
      .cnt_wdata   (cnt_wdata),
      .cnt_rdata   (cnt_rdata),
      .en_wr       (en_wr),
      .en_wdata    (en_wdata),
      .blk_en_n    (blk_en_n),
      .legacy_mode (legacy_mode),
      .beat_size   (beat_size),
      .cpu_addr    (cpu_addr),
      .beat_req    (beat_req),
      .beat_ack    (beat_ack),
      .bus_err     (bus_err),
      .busy        (busy),
      .done        (done),
      .bus_addr    (bus_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      int          acked;
      bit          seen;
      bit          first;
      logic [31:0] start_exp;
      acked = 0;
      seen  = 1'b0;
      first = 1'b1;
      start_exp = v.leg ? {v.cnt[31:24], v.cpu[23:0]} : v.cpu;
      @(negedge clk);
      legacy_mode = v.leg; beat_size = v.sz; cpu_addr = v.cpu;
      cnt_wr = 1'b1; cnt_wdata = v.cnt;
      @(negedge clk);
      cnt_wr = 1'b0;
      chk("R8 idle count write", cnt_rdata, v.cnt);
      en_wr = 1'b1; en_wdata = 1'b0;
      @(negedge clk);
      en_wr = 1'b0;
      for (int c = 0; c < 200 && !seen; c++) begin
         @(negedge clk);
         beat_ack = 1'b0; bus_err = 1'b0; cnt_wr = 1'b0;
         if (done) begin
            seen = 1'b1;
            chk("R3 busy low at end", {31'b0, busy}, 32'd0);
            chk("R3 beat_req low at end", {31'b0, beat_req}, 32'd0);
         end else if (beat_req) begin
            if (first) begin
               chk("R1 busy at first beat", {31'b0, busy}, 32'd1);
               chk("R6 R5 first beat address", bus_addr, start_exp);
               cnt_wr = 1'b1; cnt_wdata = 32'h0000_0999;   // R8 ignored while busy
               first = 1'b0;
            end
            if (acked == int'(v.errb)) begin
               bus_err  = 1'b1;
               beat_ack = v.eboth;   // R4 error wins
            end else begin
               beat_ack = 1'b1;
               acked++;
            end
         end
      end
      cnt_wr = 1'b0;
      chk("R7 done pulse seen", {31'b0, seen}, 32'd1);
      @(negedge clk);
      chk("R7 done one cycle", {31'b0, done}, 32'd0);
      chk("R7 enable bit back to 1", {31'b0, blk_en_n}, 32'd1);
      chk("R2 R4 beats before end", acked, 32'(v.beats));
      chk("R2 R8 final count", cnt_rdata, v.ecnt);
      chk("R6 R5 final address", bus_addr, v.eaddr);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 count", cnt_rdata, 32'd0);
      chk("R9 enable bit", {31'b0, blk_en_n}, 32'd1);
      chk("R9 busy", {31'b0, busy}, 32'd0);
      chk("R9 done", {31'b0, done}, 32'd0);
      chk("R9 beat_req", {31'b0, beat_req}, 32'd0);
      chk("R9 bus_addr", bus_addr, 32'd0);

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

      // R1: zero count with enable cleared starts nothing
      @(negedge clk);
      legacy_mode = 1'b0; cnt_wr = 1'b1; cnt_wdata = 32'd0;
      @(negedge clk);
      cnt_wr = 1'b0; en_wr = 1'b1; en_wdata = 1'b0;
      @(negedge clk);
      en_wr = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 no start on zero count", {31'b0, busy}, 32'd0);
      chk("R1 no request on zero count", {31'b0, beat_req}, 32'd0);
      chk("R1 enable bit kept at 0", {31'b0, blk_en_n}, 32'd0);
      en_wr = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;

      // R5: legacy mode, only upper byte set, counts as zero
      legacy_mode = 1'b1; cnt_wr = 1'b1; cnt_wdata = 32'h1200_0000;
      @(negedge clk);
      cnt_wr = 1'b0; en_wr = 1'b1; en_wdata = 1'b0;
      @(negedge clk);
      en_wr = 1'b0;
      repeat (4) @(negedge clk);
      chk("R5 upper byte alone does not start", {31'b0, busy}, 32'd0);
      chk("R5 count kept", cnt_rdata, 32'h1200_0000);
      en_wr = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
      legacy_mode = 1'b0;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule